// File: doc/BRIEF.md
# Register Alias Rename Table

This block is the renaming step of an out-of-order front end that keeps results in a reorder buffer until they commit. It has one entry for each architectural register. Each entry says whether the register's newest value is already in the committed register file, or is still being produced by an in-flight instruction. In the second case, the entry also holds the reorder-buffer slot of that producer. Looking up a register by its index therefore gives the same answer as searching every in-flight destination for the youngest match. That answer is the read-after-write check made before an instruction is dispatched.

Each cycle, up to `LANES` instructions are renamed together, in program order from lane 0 upward. For each lane, the block reports whether each of its two sources must wait on a buffer slot, and which slot. A source that names a register written by an older lane in the same group gets that lane's new slot. After the lookup, every destination is recorded with its allocated slot. A commit clears a register's pending mark only while that register still points at the committing slot. A flush returns every register to the committed file within one cycle. The committed file is the retirement-side view, where no register is pending.

Lookup outputs are combinational from the inputs and the stored table. Table updates take effect at the next rising clock edge.

Top module: `rat_rename`

## Requirements
- R1: After reset, every source of every lane reports the committed file (`src_*_buf` = 0) with tag 0.
- R2: Whenever a source reports the committed file, its tag output is 0.
- R3: A rename with `ren_valid` and `ren_dst_valid` set marks its destination pending with `ren_tag` from the next cycle. Later lookups of that register then report buffer (`src_*_buf` = 1) with that tag.
- R4: A later rename of the same register replaces the earlier mapping. The youngest producer's tag is reported.
- R5: A commit whose `commit_dst`/`commit_tag` match a pending register's stored mapping makes that register report the committed file from the next cycle.
- R6: A commit whose tag differs from the register's stored tag leaves the pending mapping unchanged.
- R7: A lookup in the same cycle as a matching commit of that register already reports the committed file.
- R8: A source in lane i that names the destination of a valid rename in a lane j < i reports buffer with lane j's tag. The highest such j wins. A lane's own destination never affects its own sources.
- R9: When several lanes of one group rename the same register, the highest lane's tag is stored.
- R10: `flush` makes every register report the committed file from the next cycle. Renames and commits presented in the flush cycle are discarded.
- R11: A rename with `ren_valid` or `ren_dst_valid` low changes no mapping.
- R12: When a rename and a matching commit hit the same register in one cycle, the rename's mapping is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard all in-flight mappings |
| ren_valid | input | LANES | Lane carries an instruction |
| ren_dst_valid | input | LANES | Lane's instruction writes a register |
| ren_dst | input | LANES*AW | Destination register per lane (lane l at bits l*AW) |
| ren_tag | input | LANES*TW | Allocated buffer slot per lane |
| ren_src_a | input | LANES*AW | First source register per lane |
| ren_src_b | input | LANES*AW | Second source register per lane |
| commit_valid | input | 1 | An instruction with a destination commits |
| commit_dst | input | AW | Committing instruction's destination |
| commit_tag | input | TW | Committing instruction's buffer slot |
| src_a_buf | output | LANES | 1: first source waits on a buffer slot, 0: read committed file |
| src_a_tag | output | LANES*TW | Buffer slot for first source |
| src_b_buf | output | LANES | 1: second source waits on a buffer slot, 0: read committed file |
| src_b_tag | output | LANES*TW | Buffer slot for second source |

## Verification
The assertions check the table's own updates on every cycle. A flush always empties it. The top lane's rename always lands. A matching commit clears its register unless a rename hits that register. A stale commit leaves its register alone, and an idle cycle changes nothing. The combinational lookup is checked only by the bench's scenarios, which compare it with a model of the table. These scenarios cover same-group bypass between lanes, a commit in the same cycle as a lookup, and rename against commit on one register. Random groups with few registers mix these collisions freely.

// File: rtl/rat_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the register alias rename table.
package rat_pkg;
    localparam int DEF_ARCH_REGS   = 16;
    localparam int DEF_ROB_ENTRIES = 32;
    localparam int DEF_LANES       = 2;

    // Where a source operand's value is read from.
    typedef enum logic {
        SRC_COMMITTED = 1'b0,
        SRC_BUFFER    = 1'b1
    } src_loc_e;
endpackage

// File: rtl/rat_front_map.sv
`timescale 1ns/1ps
// Front-end mapping table: one pending bit and one buffer slot per
// architectural register. Assumes lanes are in program order (higher lane
// is younger) and that at most one commit arrives per cycle.
module rat_front_map #(
    parameter int NUM_ARCH  = rat_pkg::DEF_ARCH_REGS,
    parameter int ROB_DEPTH = rat_pkg::DEF_ROB_ENTRIES,
    parameter int LANES     = rat_pkg::DEF_LANES,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int TW = $clog2(ROB_DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic [LANES-1:0]         ren_write,
    input  logic [LANES*AW-1:0]      ren_dst,
    input  logic [LANES*TW-1:0]      ren_tag,
    input  logic                     commit_valid,
    input  logic [AW-1:0]            commit_dst,
    input  logic [TW-1:0]            commit_tag,
    output logic [NUM_ARCH-1:0]          map_pend,
    output logic [NUM_ARCH-1:0][TW-1:0]  map_tag
);
    logic [NUM_ARCH-1:0]         pend_d;
    logic [NUM_ARCH-1:0][TW-1:0] tag_d;

    // Next state: restore on flush, else clear on matching commit, then renames.
    always_comb begin
        pend_d = map_pend;
        tag_d  = map_tag;
        if (flush) begin
            pend_d = '0;
        end else begin
            if (commit_valid && map_pend[commit_dst] &&
                (map_tag[commit_dst] == commit_tag)) begin
                pend_d[commit_dst] = 1'b0;
            end
            for (int l = 0; l < LANES; l++) begin
                if (ren_write[l]) begin
                    pend_d[ren_dst[l*AW +: AW]] = 1'b1;
                    tag_d[ren_dst[l*AW +: AW]]  = ren_tag[l*TW +: TW];
                end
            end
        end
    end

    // Table registers with synchronous reset to the committed view.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_pend <= '0;
            map_tag  <= '0;
        end else begin
            map_pend <= pend_d;
            map_tag  <= tag_d;
        end
    end
endmodule

// File: rtl/rat_src_lookup.sv
`timescale 1ns/1ps
// Resolves one source operand of lane LANE: table entry, cleared by a
// same-cycle matching commit, overridden by older lanes of the same group.
// Purely combinational.
module rat_src_lookup #(
    parameter int NUM_ARCH  = rat_pkg::DEF_ARCH_REGS,
    parameter int ROB_DEPTH = rat_pkg::DEF_ROB_ENTRIES,
    parameter int LANES     = rat_pkg::DEF_LANES,
    parameter int LANE      = 0,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int TW = $clog2(ROB_DEPTH)
) (
    input  logic [AW-1:0]                src,
    input  logic [NUM_ARCH-1:0]          map_pend,
    input  logic [NUM_ARCH-1:0][TW-1:0]  map_tag,
    input  logic                         commit_valid,
    input  logic [AW-1:0]                commit_dst,
    input  logic [TW-1:0]                commit_tag,
    input  logic [LANES-1:0]             ren_write,
    input  logic [LANES*AW-1:0]          ren_dst,
    input  logic [LANES*TW-1:0]          ren_tag,
    output logic                         is_buf,
    output logic [TW-1:0]                tag
);
    import rat_pkg::*;

    src_loc_e      loc;
    logic [TW-1:0] slot;

    // Pick the youngest visible producer of src.
    always_comb begin
        loc  = map_pend[src] ? SRC_BUFFER : SRC_COMMITTED;
        slot = map_tag[src];
        if (commit_valid && (commit_dst == src) && (commit_tag == slot)) begin
            loc = SRC_COMMITTED;
        end
        for (int j = 0; j < LANES; j++) begin
            if ((j < LANE) && ren_write[j] && (ren_dst[j*AW +: AW] == src)) begin
                loc  = SRC_BUFFER;
                slot = ren_tag[j*TW +: TW];
            end
        end
    end

    // Committed sources carry a zero tag.
    assign is_buf = (loc == SRC_BUFFER);
    assign tag    = is_buf ? slot : '0;
endmodule

// File: rtl/rat_rename.sv
`timescale 1ns/1ps
// Register alias rename table top: the front-end map plus one lookup per
// lane and source. Assumes allocated tags are unique among in-flight slots.
module rat_rename #(
    parameter int NUM_ARCH  = rat_pkg::DEF_ARCH_REGS,
    parameter int ROB_DEPTH = rat_pkg::DEF_ROB_ENTRIES,
    parameter int LANES     = rat_pkg::DEF_LANES,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int TW = $clog2(ROB_DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic [LANES-1:0]      ren_valid,
    input  logic [LANES-1:0]      ren_dst_valid,
    input  logic [LANES*AW-1:0]   ren_dst,
    input  logic [LANES*TW-1:0]   ren_tag,
    input  logic [LANES*AW-1:0]   ren_src_a,
    input  logic [LANES*AW-1:0]   ren_src_b,
    input  logic                  commit_valid,
    input  logic [AW-1:0]         commit_dst,
    input  logic [TW-1:0]         commit_tag,
    output logic [LANES-1:0]      src_a_buf,
    output logic [LANES*TW-1:0]   src_a_tag,
    output logic [LANES-1:0]      src_b_buf,
    output logic [LANES*TW-1:0]   src_b_tag
);
    logic [LANES-1:0]            ren_write;
    logic [NUM_ARCH-1:0]         map_pend;
    logic [NUM_ARCH-1:0][TW-1:0] map_tag;

    // A lane writes the table only when it is valid and has a destination.
    assign ren_write = ren_valid & ren_dst_valid;

    rat_front_map #(.NUM_ARCH(NUM_ARCH), .ROB_DEPTH(ROB_DEPTH), .LANES(LANES)) u_map (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .ren_write(ren_write), .ren_dst(ren_dst), .ren_tag(ren_tag),
        .commit_valid(commit_valid), .commit_dst(commit_dst), .commit_tag(commit_tag),
        .map_pend(map_pend), .map_tag(map_tag)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        rat_src_lookup #(.NUM_ARCH(NUM_ARCH), .ROB_DEPTH(ROB_DEPTH),
                         .LANES(LANES), .LANE(l)) u_src_a (
            .src(ren_src_a[l*AW +: AW]), .map_pend(map_pend), .map_tag(map_tag),
            .commit_valid(commit_valid), .commit_dst(commit_dst), .commit_tag(commit_tag),
            .ren_write(ren_write), .ren_dst(ren_dst), .ren_tag(ren_tag),
            .is_buf(src_a_buf[l]), .tag(src_a_tag[l*TW +: TW])
        );
        rat_src_lookup #(.NUM_ARCH(NUM_ARCH), .ROB_DEPTH(ROB_DEPTH),
                         .LANES(LANES), .LANE(l)) u_src_b (
            .src(ren_src_b[l*AW +: AW]), .map_pend(map_pend), .map_tag(map_tag),
            .commit_valid(commit_valid), .commit_dst(commit_dst), .commit_tag(commit_tag),
            .ren_write(ren_write), .ren_dst(ren_dst), .ren_tag(ren_tag),
            .is_buf(src_b_buf[l]), .tag(src_b_tag[l*TW +: TW])
        );
    end
endmodule

// File: rtl/rat_rename_checker.sv
`timescale 1ns/1ps
// Temporal checks on the rename table's stored state, bound into rat_rename.
module rat_rename_checker #(
    parameter int NUM_ARCH  = rat_pkg::DEF_ARCH_REGS,
    parameter int ROB_DEPTH = rat_pkg::DEF_ROB_ENTRIES,
    parameter int LANES     = rat_pkg::DEF_LANES,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int TW = $clog2(ROB_DEPTH),
    localparam int HI = LANES - 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         flush,
    input logic [LANES-1:0]             ren_valid,
    input logic [LANES-1:0]             ren_dst_valid,
    input logic [LANES*AW-1:0]          ren_dst,
    input logic [LANES*TW-1:0]          ren_tag,
    input logic                         commit_valid,
    input logic [AW-1:0]                commit_dst,
    input logic [TW-1:0]                commit_tag,
    input logic [NUM_ARCH-1:0]          map_pend,
    input logic [NUM_ARCH-1:0][TW-1:0]  map_tag
);
    logic ren_hits_commit;
    logic any_ren;

    // Does any writing lane target the committing register this cycle?
    always_comb begin
        ren_hits_commit = 1'b0;
        any_ren         = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (ren_valid[l] && ren_dst_valid[l]) begin
                any_ren = 1'b1;
                if (ren_dst[l*AW +: AW] == commit_dst) ren_hits_commit = 1'b1;
            end
        end
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (map_pend == '0)); // R10

    AST_TOP_LANE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && ren_valid[HI] && ren_dst_valid[HI]) |=>
        (map_pend[$past(ren_dst[HI*AW +: AW])] &&
         map_tag[$past(ren_dst[HI*AW +: AW])] == $past(ren_tag[HI*TW +: TW]))); // R3

    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && commit_valid && map_pend[commit_dst] &&
         map_tag[commit_dst] == commit_tag && !ren_hits_commit) |=>
        !map_pend[$past(commit_dst)]); // R5

    AST_STALE_COMMIT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && commit_valid && map_tag[commit_dst] != commit_tag && !ren_hits_commit) |=>
        (map_pend[$past(commit_dst)] == $past(map_pend[commit_dst]))); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !any_ren && !commit_valid) |=>
        ($stable(map_pend) && $stable(map_tag))); // R11
endmodule

bind rat_rename rat_rename_checker #(
    .NUM_ARCH(NUM_ARCH), .ROB_DEPTH(ROB_DEPTH), .LANES(LANES)
) u_rat_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ren_valid(ren_valid), .ren_dst_valid(ren_dst_valid),
    .ren_dst(ren_dst), .ren_tag(ren_tag),
    .commit_valid(commit_valid), .commit_dst(commit_dst), .commit_tag(commit_tag),
    .map_pend(map_pend), .map_tag(map_tag)
);

// File: tb/rat_rename_bench.sv
`timescale 1ns/1ps
module rat_rename_bench;
    localparam int NA = 16;
    localparam int ND = 32;
    localparam int L  = 2;
    localparam int AW = 4;
    localparam int TW = 5;

    logic clk = 1'b0;
    logic rst_n;
    always #10 clk = ~clk;

    // Driven inputs
    logic              flush, commit_valid;
    logic [AW-1:0]     commit_dst;
    logic [TW-1:0]     commit_tag;
    logic [L-1:0]      rv, dv;
    logic [AW-1:0]     dst [L];
    logic [AW-1:0]     sa  [L];
    logic [AW-1:0]     sb  [L];
    logic [TW-1:0]     tg  [L];
    // Staged values, copied onto the driven inputs at a falling edge
    logic              s_flush, s_cv;
    logic [AW-1:0]     s_cd;
    logic [TW-1:0]     s_ct;
    logic [L-1:0]      s_rv, s_dv;
    logic [AW-1:0]     s_dst [L];
    logic [AW-1:0]     s_sa  [L];
    logic [AW-1:0]     s_sb  [L];
    logic [TW-1:0]     s_tg  [L];

    logic [L*AW-1:0] ren_dst, ren_src_a, ren_src_b;
    logic [L*TW-1:0] ren_tag, src_a_tag, src_b_tag;
    logic [L-1:0]    src_a_buf, src_b_buf;

    for (genvar l = 0; l < L; l++) begin : g_pack
        assign ren_dst[l*AW +: AW]   = dst[l];
        assign ren_src_a[l*AW +: AW] = sa[l];
        assign ren_src_b[l*AW +: AW] = sb[l];
        assign ren_tag[l*TW +: TW]   = tg[l];
    end

    rat_rename u_rat_rename (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .ren_valid(rv), .ren_dst_valid(dv), .ren_dst(ren_dst), .ren_tag(ren_tag),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
        .commit_valid(commit_valid), .commit_dst(commit_dst), .commit_tag(commit_tag),
        .src_a_buf(src_a_buf), .src_a_tag(src_a_tag),
        .src_b_buf(src_b_buf), .src_b_tag(src_b_tag)
    );

    // Reference table
    bit            ref_pend [NA];
    logic [TW-1:0] ref_tag  [NA];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Expected {buf, tag} for a source of a lane, from the requirements.
    function automatic logic [TW:0] expect_src(int lane, logic [AW-1:0] s);
        bit            p = ref_pend[s];
        logic [TW-1:0] t = ref_tag[s];
        if (commit_valid && commit_dst == s && commit_tag == t) p = 0;  // R7
        for (int j = 0; j < lane; j++)
            if (rv[j] && dv[j] && dst[j] == s) begin p = 1; t = tg[j]; end  // R8
        if (!p) t = '0;  // R2
        return {p, t};
    endfunction

    task automatic chk(string lbl, int lane, string which, logic [AW-1:0] s,
                       logic b, logic [TW-1:0] t);
        logic [TW:0] e = expect_src(lane, s);
        checks++;
        if ({b, t} !== e) begin
            fails++;
            $display("FAIL %s lane%0d src_%s reg%0d: actual buf=%0b tag=%0d expected buf=%0b tag=%0d",
                     lbl, lane, which, s, b, t, e[TW], e[TW-1:0]);
        end
    endtask

    task automatic clr_stage();
        s_flush = 0; s_cv = 0; s_cd = '0; s_ct = '0; s_rv = '0; s_dv = '0;
        for (int l = 0; l < L; l++) begin
            s_dst[l] = '0; s_sa[l] = '0; s_sb[l] = '0; s_tg[l] = '0;
        end
    endtask

    task automatic ren(int l, logic d, logic [AW-1:0] r, logic [TW-1:0] t);
        s_rv[l] = 1; s_dv[l] = d; s_dst[l] = r; s_tg[l] = t;
    endtask

    // One cycle: apply staged inputs, check lookups, advance the model.
    task automatic tick(string lbl);
        @(negedge clk);
        flush = s_flush; commit_valid = s_cv; commit_dst = s_cd; commit_tag = s_ct;
        rv = s_rv; dv = s_dv;
        for (int l = 0; l < L; l++) begin
            dst[l] = s_dst[l]; sa[l] = s_sa[l]; sb[l] = s_sb[l]; tg[l] = s_tg[l];
        end
        #8;
        if (!flush) begin
            for (int l = 0; l < L; l++) begin
                chk(lbl, l, "a", sa[l], src_a_buf[l], src_a_tag[l*TW +: TW]);
                chk(lbl, l, "b", sb[l], src_b_buf[l], src_b_tag[l*TW +: TW]);
            end
        end
        if (flush) begin
            for (int r = 0; r < NA; r++) ref_pend[r] = 0;  // R10
        end else begin
            if (commit_valid && ref_pend[commit_dst] && ref_tag[commit_dst] == commit_tag)
                ref_pend[commit_dst] = 0;  // R5
            for (int l = 0; l < L; l++)
                if (rv[l] && dv[l]) begin ref_pend[dst[l]] = 1; ref_tag[dst[l]] = tg[l]; end
        end
        @(posedge clk);
    endtask

    task automatic look(int l, logic [AW-1:0] a, logic [AW-1:0] b);
        s_sa[l] = a; s_sb[l] = b;
    endtask

    initial begin : watchdog
        #3000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5EED_0017));
        clr_stage();
        flush = 0; commit_valid = 0; commit_dst = '0; commit_tag = '0; rv = '0; dv = '0;
        for (int l = 0; l < L; l++) begin dst[l] = '0; sa[l] = '0; sb[l] = '0; tg[l] = '0; end
        for (int r = 0; r < NA; r++) begin ref_pend[r] = 0; ref_tag[r] = '0; end
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: every register committed after reset
        for (int r = 0; r < NA; r += 4) begin
            clr_stage(); look(0, AW'(r), AW'(r+1)); look(1, AW'(r+2), AW'(r+3));
            tick("R1");
        end
        // R8 and R9: same-group bypass; both lanes write r3
        clr_stage(); ren(0, 1, 4'd3, 5'd5); ren(1, 1, 4'd3, 5'd6);
        look(0, 4'd3, 4'd3); look(1, 4'd3, 4'd0); tick("R8");
        clr_stage(); look(0, 4'd3, 4'd1); tick("R9");
        // R6: stale commit keeps the mapping, same cycle and next
        clr_stage(); s_cv = 1; s_cd = 4'd3; s_ct = 5'd5; look(0, 4'd3, 4'd3); tick("R6");
        clr_stage(); look(1, 4'd3, 4'd3); tick("R6");
        // R7 then R5: matching commit
        clr_stage(); s_cv = 1; s_cd = 4'd3; s_ct = 5'd6; look(0, 4'd3, 4'd2); tick("R7");
        clr_stage(); look(0, 4'd3, 4'd3); tick("R5");
        // R11: rename without a destination, or not valid, changes nothing
        clr_stage(); ren(0, 0, 4'd4, 5'd7); s_dv[1] = 1; s_dst[1] = 4'd4; s_tg[1] = 5'd8;
        tick("R11");
        clr_stage(); look(0, 4'd4, 4'd4); look(1, 4'd4, 4'd4); tick("R11");
        // R12: rename and matching commit on one register
        clr_stage(); ren(0, 1, 4'd5, 5'd9); tick("R12");
        clr_stage(); s_cv = 1; s_cd = 4'd5; s_ct = 5'd9; ren(0, 1, 4'd5, 5'd10); tick("R12");
        clr_stage(); look(0, 4'd5, 4'd5); tick("R12");
        // R4: later rename replaces the earlier mapping
        clr_stage(); ren(1, 1, 4'd2, 5'd1); tick("R4");
        clr_stage(); ren(0, 1, 4'd2, 5'd2); tick("R4");
        clr_stage(); look(0, 4'd2, 4'd2); look(1, 4'd2, 4'd5); tick("R4");
        // R10: flush discards renames and commits in its cycle
        clr_stage(); s_flush = 1; ren(0, 1, 4'd8, 5'd11); s_cv = 1; s_cd = 4'd2; s_ct = 5'd2;
        tick("R10");
        clr_stage(); look(0, 4'd5, 4'd8); look(1, 4'd2, 4'd3); tick("R10");

        // Random groups over a few registers, checked by R3 and R2 to R12 rules
        for (int i = 0; i < 600; i++) begin
            clr_stage();
            for (int l = 0; l < L; l++) begin
                if ($urandom % 4 != 0) ren(l, ($urandom % 5 != 0), AW'($urandom % 6), TW'($urandom));
                look(l, AW'($urandom % 6), AW'($urandom % 6));
            end
            if ($urandom % 3 == 0) begin
                s_cv = 1; s_cd = AW'($urandom % 6);
                s_ct = ($urandom % 4 != 0) ? ref_tag[s_cd] : TW'($urandom);
            end
            s_flush = ($urandom % 40 == 0);
            tick("R3");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule